// File: doc/BRIEF.md
# Ramp Converter Sequencer with Result Filter

This block is the digital half of a 6-bit single-slope converter. It starts each conversion with a one-cycle restart strobe. It then steps a ramp code upward from 0 toward an external ramp generator. It watches a comparator that reports when the ramp has reached the sampled input. The ramp value at that moment becomes the raw code. If the comparator never reports a crossing, the raw code is the top value.

Raw codes pass through a result filter before they reach the published register. That register drives the table row select and a readable status location. By default, a new value is published only after the same code has come out of several back-to-back conversions. A configuration bit removes the filter, and then every conversion publishes its code. A one-cycle update strobe marks every load of the published register.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `result`, `updateStrobe`, `convReset` and `rampCode` are all 0.
- R2: Each conversion begins with `convReset` high for exactly one cycle, with `rampCode` equal to 0. In the following cycles `rampCode` takes the values 0, 1, 2, … one step per cycle. Outside the ramp phase `rampCode` is 0.
- R3: The raw code is the `rampCode` value of the first ramp cycle in which `cmpAbove` is 1. The ramp then stops and `rampCode` returns to 0 in the next cycle.
- R4: If `cmpAbove` stays 0 through the ramp cycle with code 63, the conversion ends in that cycle with raw code 63.
- R5: With `filterOff` = 0, `result` is loaded only on a conversion that makes four consecutive conversions with the same raw code. Fewer matches leave `result` unchanged and give no strobe.
- R6: With `filterOff` = 0, a raw code that differs from the one before it restarts the match run at one.
- R7: With `filterOff` = 0, once four matches are reached, each further conversion with the same code loads `result` again and strobes again.
- R8: With `filterOff` = 1, every conversion loads its raw code into `result` and strobes.
- R9: `updateStrobe` is a single-cycle pulse. It is high in the cycle `result` takes its new value, which is code+3 cycles after the `convReset` cycle of that conversion.
- R10: With `runEn` = 0 in idle, no conversion starts. With `runEn` held at 1, conversions run back to back, so `convReset` comes code+3 cycles after the previous one.
- R11: Reset clears the match history. Matches seen before a reset do not count toward the four needed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Start or keep running conversions |
| filterOff | input | 1 | 1 publishes every conversion; 0 enables the four-match filter |
| cmpAbove | input | 1 | Comparator: ramp has reached the input |
| rampCode | output | 6 | Ramp code to the external ramp DAC |
| convReset | output | 1 | One-cycle restart strobe at conversion start |
| result | output | 6 | Published conversion result |
| updateStrobe | output | 1 | One-cycle pulse on every load of `result` |

## Verification
The bench checks the filter boundaries: three matches must not publish, the fourth must publish, and the fifth must publish again. A design that miscounts would publish early, publish late, or go silent after saturation. A single differing code placed in the middle of a run must restart the count. A design that only counts equal codes without resetting the run would publish too soon. The bench also covers the extreme codes: 0, where the comparator trips in the first ramp cycle, and an input the ramp never reaches, where a wrong design would wrap or hang instead of ending at 63. Two more cases are a reset that falls partway through a run of matches, and back-to-back conversions, where a wrong design would keep the stale history or mistime the restart strobe.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CLEAR = 2'd1,
    SEQ_RAMP  = 2'd2,
    SEQ_DONE  = 2'd3
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearRamp;
    logic stepRamp;
    logic capture;
    logic convDone;
  } ctrlStrobe_t;

endpackage

// File: rtl/ramp_seq_ctrl.sv
module ramp_seq_ctrl
  import ramp_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cmpAbove,
  input  logic        rampAtTop,
  output ctrlStrobe_t strobe,
  output logic        convReset
);

  seqState_t state, stateNext;
  logic      hit;

  assign hit = (state == SEQ_RAMP) && (cmpAbove || rampAtTop);

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:  if (runEn) stateNext = SEQ_CLEAR;
      SEQ_CLEAR: stateNext = SEQ_RAMP;
      SEQ_RAMP:  if (hit) stateNext = SEQ_DONE;
      SEQ_DONE:  stateNext = runEn ? SEQ_CLEAR : SEQ_IDLE;
      default:   stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearRamp = (state == SEQ_CLEAR);
    strobe.capture   = hit;
    strobe.stepRamp  = (state == SEQ_RAMP) && !hit;
    strobe.convDone  = (state == SEQ_DONE);
  end

  assign convReset = (state == SEQ_CLEAR);

  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && !runEn) |=> !convReset); // R10

endmodule

// File: rtl/code_filter.sv
module code_filter #(
  parameter int CODE_W      = 6,
  parameter int MATCH_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              filterOff,
  input  logic [CODE_W-1:0] rawCode,
  output logic [CODE_W-1:0] result,
  output logic              updateStrobe
);

  localparam int LEN_W = $clog2(MATCH_COUNT + 1);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MATCH_COUNT);

  logic [CODE_W-1:0] prevCode;
  logic [LEN_W-1:0]  runLen, runLenNext;
  logic              publish;

  // Run length counts the present conversion; zero means empty history
  always_comb begin
    if (runLen != '0 && rawCode == prevCode)
      runLenNext = (runLen == LEN_SAT) ? LEN_SAT : runLen + LEN_W'(1);
    else
      runLenNext = LEN_W'(1);
    publish = filterOff || (runLenNext == LEN_SAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode     <= '0;
      runLen       <= '0;
      result       <= '0;
      updateStrobe <= 1'b0;
    end else begin
      updateStrobe <= 1'b0;
      if (convDone) begin
        prevCode <= rawCode;
        runLen   <= runLenNext;
        if (publish) begin
          result       <= rawCode;
          updateStrobe <= 1'b1;
        end
      end
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updateStrobe |-> $stable(result)); // R5
  AST_UPDATE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |-> $past(convDone)); // R9
  AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe); // R9

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int MATCH_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              filterOff,
  output logic [CODE_W-1:0] rampCode,
  output logic              rampAtTop,
  output logic [CODE_W-1:0] result,
  output logic              updateStrobe
);

  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  logic [CODE_W-1:0] rampCnt;
  logic [CODE_W-1:0] rawCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCnt <= '0;
      rawCode <= '0;
    end else begin
      if (strobe.capture) rawCode <= rampCnt;
      if (strobe.clearRamp || strobe.capture) rampCnt <= '0;
      else if (strobe.stepRamp)               rampCnt <= rampCnt + CODE_W'(1);
    end
  end

  assign rampCode  = rampCnt;
  assign rampAtTop = (rampCnt == CODE_TOP);

  code_filter #(
    .CODE_W      (CODE_W),
    .MATCH_COUNT (MATCH_COUNT)
  ) uFilter (
    .clk          (clk),
    .rstN         (rstN),
    .convDone     (strobe.convDone),
    .filterOff    (filterOff),
    .rawCode      (rawCode),
    .result       (result),
    .updateStrobe (updateStrobe)
  );

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int MATCH_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              filterOff,
  input  logic              cmpAbove,
  output logic [CODE_W-1:0] rampCode,
  output logic              convReset,
  output logic [CODE_W-1:0] result,
  output logic              updateStrobe
);

  ctrlStrobe_t strobe;
  logic        rampAtTop;

  ramp_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .cmpAbove  (cmpAbove),
    .rampAtTop (rampAtTop),
    .strobe    (strobe),
    .convReset (convReset)
  );

  ramp_datapath #(
    .CODE_W      (CODE_W),
    .MATCH_COUNT (MATCH_COUNT)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .filterOff    (filterOff),
    .rampCode     (rampCode),
    .rampAtTop    (rampAtTop),
    .result       (result),
    .updateStrobe (updateStrobe)
  );

  AST_CONVRESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convReset |=> !convReset); // R2
  AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    convReset |=> (rampCode == '0)); // R2

endmodule

// File: tb/tb_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module tb_ramp_adc_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       filterOff = 1'b0;
  logic       cmpAbove;
  logic [5:0] rampCode;
  logic       convReset;
  logic [5:0] result;
  logic       updateStrobe;
  int         vin = 0;

  int nChecks = 0;
  int nFails  = 0;

  // Bench reference state
  int refPrev = 0;
  int refLen  = 0;
  int refResult = 0;

  always #2.5 clk = ~clk;

  assign cmpAbove = (int'(rampCode) >= vin);

  ramp_adc_ctrl dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .filterOff(filterOff),
    .cmpAbove(cmpAbove), .rampCode(rampCode), .convReset(convReset),
    .result(result), .updateStrobe(updateStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    runEn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(result == 0 && updateStrobe == 0 && convReset == 0 && rampCode == 0,
          "R1 during reset", int'(result), 0);
    rstN = 1'b1;
    refPrev = 0; refLen = 0; refResult = 0;
    @(negedge clk);
    check(result == 0 && updateStrobe == 0 && convReset == 0 && rampCode == 0,
          "R1 after release", int'(result), 0);
  endtask

  // Bench model of one finished conversion; returns whether it publishes
  function automatic bit modelConv(input int code);
    int len;
    len = (refLen != 0 && code == refPrev) ? ((refLen >= 4) ? 4 : refLen + 1) : 1;
    refPrev = code;
    refLen = len;
    if (filterOff || len == 4) begin
      refResult = code;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // One isolated conversion with ramp, timing and filter checks
  task automatic convOnce(input int v, input string req);
    int code;
    bit expUpd;
    bit rampOk;
    vin = v;
    code = (v > 63) ? 63 : v;
    runEn = 1'b1;
    do @(negedge clk); while (!convReset);
    runEn = 1'b0;
    check(rampCode == 0, "R2 ramp zero at restart", int'(rampCode), 0);
    rampOk = 1'b1;
    for (int i = 0; i <= code; i++) begin
      @(negedge clk);
      if (int'(rampCode) != i || convReset) rampOk = 1'b0;
    end
    check(rampOk, "R2 ramp steps by one", int'(rampCode), code);
    @(negedge clk);
    check(rampCode == 0 && updateStrobe == 0,
          code == 63 ? "R4 ramp stops at top" : "R3 ramp stops after trip",
          int'(rampCode), 0);
    expUpd = modelConv(code);
    @(negedge clk);
    check(updateStrobe == expUpd, {req, " strobe (R9 timing)"}, int'(updateStrobe), int'(expUpd));
    check(int'(result) == refResult, {req, " result"}, int'(result), refResult);
    @(negedge clk);
    check(updateStrobe == 0 && convReset == 0, "R9 single pulse, R10 idle", int'(updateStrobe), 0);
  endtask

  task automatic testFilterRun();
    filterOff = 1'b0;
    for (int n = 0; n < 3; n++) convOnce(20, "R5 below four matches");
    convOnce(20, "R5 fourth match publishes");
    convOnce(20, "R7 saturated run republishes");
  endtask

  task automatic testTopCode();
    filterOff = 1'b0;
    for (int n = 0; n < 4; n++) convOnce(70, "R4 untripped gives 63");
    check(result == 63, "R4 published top code", int'(result), 63);
  endtask

  task automatic testRestart();
    filterOff = 1'b0;
    for (int n = 0; n < 3; n++) convOnce(30, "R6 run a");
    convOnce(31, "R6 odd code");
    for (int n = 0; n < 3; n++) convOnce(30, "R6 restarted run");
    check(result == 63, "R6 no early publish", int'(result), 63);
    convOnce(30, "R6 fourth after restart");
  endtask

  task automatic testNoFilter();
    filterOff = 1'b1;
    convOnce(0, "R8 min code");
    convOnce(45, "R8 every conversion");
    convOnce(7, "R8 every conversion");
    filterOff = 1'b0;
  endtask

  task automatic testHistoryReset();
    filterOff = 1'b0;
    for (int n = 0; n < 3; n++) convOnce(9, "R11 pre reset");
    doReset();
    for (int n = 0; n < 3; n++) convOnce(9, "R11 history cleared");
    check(result == 0, "R11 no publish on stale history", int'(result), 0);
    convOnce(9, "R11 fourth after reset");
  endtask

  task automatic testContinuous();
    int gap;
    bit quiet;
    filterOff = 1'b1;
    repeat (20) @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (convReset) quiet = 1'b0;
    end
    check(quiet, "R10 idle without runEn", 0, 0);
    vin = 12;
    runEn = 1'b1;
    do @(negedge clk); while (!convReset);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!convReset && gap < 200);
    check(gap == 15, "R10 back-to-back period", gap, 15);
    check(updateStrobe == 1 && result == 12, "R9 strobe with next restart", int'(result), 12);
    runEn = 1'b0;
    repeat (80) @(negedge clk);
    doReset();
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    testFilterRun();
    testTopCode();
    testRestart();
    testNoFilter();
    testHistoryReset();
    testContinuous();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule